// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a serial port. It decodes single-cycle reads and writes from a 32-bit register bus with a byte address and a 4 KiB window. It holds the control, FIFO-control, baud and millisecond storage, and it builds the status words from the state of a one-character receive holding register. Toward the transmitter it puts out a byte strobe. From the receiver it takes a byte or a break indication, accepted through a ready signal. It drives one interrupt line.

There are no FIFOs. A single holding register stands in for the receive queue, and reading it empties it. A transmit write is passed straight on, so transmit-ready never falls. The baud and FIFO registers only store what software writes. Writing control register 2 with its bit 0 cleared resets the register state, the same as a reset from software.

Top module: `uart_regs`

## Requirements
- R1: The word index is address bits [11:2]. The indices are: 0x00 receive data, 0x10 transmit data, 0x20/0x21/0x22/0x23 control 1 to 4, 0x24 FIFO control, 0x25/0x26 status 1/2, 0x29 baud increment, 0x2A modulator, 0x2B baud count, 0x2C millisecond, 0x2D test. Any other index reads as 0 and ignores writes.
- R2: Read data appears on `bus_rdata` in the cycle after the request and is 0 in every cycle that does not follow a read.
- R3: Control 1, 2, 3, FIFO control, modulator and millisecond keep only bits [15:0] of a write and read them back. A write to index 0x29 lands in the baud count, which is read at 0x2B. Indices 0x23 and 0x29 read 0. Writes to 0x23, 0x2B and 0x2D have no effect.
- R4: After reset, the registers read as follows: status 1 is 0x6040 (transmit-ready bit 13, receiver-idle bit 6, RTS-state bit 14); status 2 is 0x4028 (bit 14, transmit-complete bit 3, DCD-in bit 5); test is 0x0060 (RX-empty bit 5, TX-empty bit 6); control 1, FIFO, modulator and millisecond are 0; control 2 is 0x0001; control 3 is 0x0700; baud count is 4; receive data is 0x4000 (error bit 14).
- R5: A write to control 2 with bit 0 at 0 restores every R4 value except FIFO control and millisecond, and stores the written low 16 bits with bit 0 forced to 1.
- R6: A write to transmit data pulses `tx_valid` for one cycle, one cycle later, carrying the low byte, but only when control 2 bit 2 is set. Status 1 bit 13 stays 1.
- R7: `rx_ready` is high exactly while status 1 bit 9 (receive-ready) is clear. An accepted byte sets status 1 bit 9 and status 2 bit 0, clears test bit 5, and is stored in bits [7:0] of the buffer. An accepted break stores 0x0800 (bit 11).
- R8: A receive-data read while the buffer is full returns the buffer with bit 15 set and empties the buffer. A read while it is empty returns the buffer without bit 15 and changes nothing.
- R9: `irq` = (status1[13] & control1[13] & control1[6]) | (status1[9] & control1[9]).
- R10: Writes to status 1 clear only bits {15,12,11,10,8,7,5,4} that are written as 1. Writes to status 2 clear only bits {15,13,12,11,10,8,7,6,4,2,1} that are written as 1. No other status bit changes, so receive-ready, data-ready, transmit-ready and the reset-set bits survive a write of 0xFFFF.
- R11: If a byte arrives in the same cycle as a soft-reset write, the reset wins and the byte is lost. If a byte arrives in the same cycle as a receive-data read of an empty buffer, the read returns the old buffer and the byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle each |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Receiver offers a character |
| rx_break | input | 1 | The offered character is a break |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Holding register can take a character |
| irq | output | 1 | Interrupt request |

## Verification
The receive holding register can be changed by the receiver and by the bus in the same cycle. The bench provokes this by raising `rx_valid` in the same cycle as two kinds of bus request. The first is a soft-reset write to control 2: the reset must win and leave the buffer empty with the error pattern. The second is a receive-data read of an empty buffer: the read must return the old contents, and a second read must return the new byte with bit 15 set. Random traffic from a fixed seed mixes arrivals, reads and writes to every index, and each result is compared with a bench model of the registers.

// File: rtl/uart_regs_pkg.sv
// Package: shared constants and types for the serial port register front end.
// Assumes a 16-bit register payload and a 10-bit word index.
package uart_regs_pkg;

    localparam int REG_W = 16;
    localparam int IDX_W = 10;

    // Word indices; these select behaviour, so they are fixed.
    localparam logic [IDX_W-1:0] IX_RXD  = 10'h000;
    localparam logic [IDX_W-1:0] IX_TXD  = 10'h010;
    localparam logic [IDX_W-1:0] IX_CR1  = 10'h020;
    localparam logic [IDX_W-1:0] IX_CR2  = 10'h021;
    localparam logic [IDX_W-1:0] IX_CR3  = 10'h022;
    localparam logic [IDX_W-1:0] IX_CR4  = 10'h023;
    localparam logic [IDX_W-1:0] IX_FCR  = 10'h024;
    localparam logic [IDX_W-1:0] IX_SR1  = 10'h025;
    localparam logic [IDX_W-1:0] IX_SR2  = 10'h026;
    localparam logic [IDX_W-1:0] IX_BINC = 10'h029;
    localparam logic [IDX_W-1:0] IX_BMOD = 10'h02A;
    localparam logic [IDX_W-1:0] IX_BCNT = 10'h02B;
    localparam logic [IDX_W-1:0] IX_MSEC = 10'h02C;
    localparam logic [IDX_W-1:0] IX_TEST = 10'h02D;

    // Bit positions that other logic decodes.
    localparam int B_RXD_CHRDY = 15;
    localparam int B_SR1_TXRDY = 13;
    localparam int B_SR1_RXRDY = 9;
    localparam int B_SR2_DRDY  = 0;
    localparam int B_CR1_TXEIE = 6;
    localparam int B_CR2_NRST  = 0;
    localparam int B_CR2_TXON  = 2;
    localparam int B_TST_RXMT  = 5;

    // Reset patterns and write-one-to-clear masks.
    localparam logic [REG_W-1:0] RV_SR1  = 16'h6040;
    localparam logic [REG_W-1:0] RV_SR2  = 16'h4028;
    localparam logic [REG_W-1:0] RV_TEST = 16'h0040; // RX-empty added from state
    localparam logic [REG_W-1:0] RV_CR2  = 16'h0001;
    localparam logic [REG_W-1:0] RV_CR3  = 16'h0700;
    localparam logic [REG_W-1:0] RV_BCNT = 16'h0004;
    localparam logic [REG_W-1:0] RV_RBUF = 16'h4000;
    localparam logic [REG_W-1:0] BRK_PAT = 16'h0800;
    localparam logic [REG_W-1:0] W1C_SR1 = 16'h9DB0;
    localparam logic [REG_W-1:0] W1C_SR2 = 16'hBDD6;

    typedef struct packed {
        logic txd;
        logic cr1;
        logic cr2;
        logic cr3;
        logic fcr;
        logic sr1;
        logic sr2;
        logic bcnt;
        logic bmod;
        logic msec;
    } wr_sel_t;

    typedef enum logic [3:0] {
        RS_NONE, RS_RXD, RS_CR1, RS_CR2, RS_CR3, RS_FCR, RS_SR1,
        RS_SR2, RS_BMOD, RS_BCNT, RS_MSEC, RS_TEST
    } rd_sel_t;

endpackage

// File: rtl/uart_reg_decode.sv
// Module: turns one bus request into a write strobe set and a read select.
// Assumes at most one request per cycle; unknown indices decode to nothing.
module uart_reg_decode
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_sel_t           wr,
    output rd_sel_t           rd
);

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_addr_lo;

    assign idx            = IDX_W'(bus_addr[ADDR_W-1:2]);
    assign unused_addr_lo = bus_addr[1:0];

    // Decode the word index for the current request.
    always_comb begin
        wr = '0;
        rd = RS_NONE;
        if (bus_req && bus_we) begin
            case (idx)
                IX_TXD:  wr.txd  = 1'b1;
                IX_CR1:  wr.cr1  = 1'b1;
                IX_CR2:  wr.cr2  = 1'b1;
                IX_CR3:  wr.cr3  = 1'b1;
                IX_FCR:  wr.fcr  = 1'b1;
                IX_SR1:  wr.sr1  = 1'b1;
                IX_SR2:  wr.sr2  = 1'b1;
                IX_BINC: wr.bcnt = 1'b1;
                IX_BMOD: wr.bmod = 1'b1;
                IX_MSEC: wr.msec = 1'b1;
                default: wr      = '0;
            endcase
        end else if (bus_req) begin
            case (idx)
                IX_RXD:  rd = RS_RXD;
                IX_CR1:  rd = RS_CR1;
                IX_CR2:  rd = RS_CR2;
                IX_CR3:  rd = RS_CR3;
                IX_FCR:  rd = RS_FCR;
                IX_SR1:  rd = RS_SR1;
                IX_SR2:  rd = RS_SR2;
                IX_BMOD: rd = RS_BMOD;
                IX_BCNT: rd = RS_BCNT;
                IX_MSEC: rd = RS_MSEC;
                IX_TEST: rd = RS_TEST;
                default: rd = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_hold.sv
// Module: one-character receive holding register with its full flag.
// Assumes pop is only meaningful while full; soft reset beats everything.
module uart_rx_hold
    import uart_regs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              pop,
    output logic              full,
    output logic [REG_W-1:0]  hold
);

    logic accept;

    assign accept = rx_valid && !full;

    // Track fill state and contents of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            full <= 1'b0;
            hold <= RV_RBUF;
        end else if (pop && full) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
            hold <= rx_break ? BRK_PAT : {{(REG_W-BYTE_W){1'b0}}, rx_byte};
        end
    end

endmodule

// File: rtl/uart_irq_gen.sv
// Module: interrupt request from status 1 and control 1 bits.
// Assumes both words are registered; output is combinational.
module uart_irq_gen
    import uart_regs_pkg::*;
(
    input  logic [REG_W-1:0] sr1,
    input  logic [REG_W-1:0] cr1,
    output logic             irq
);

    logic tx_term;
    logic rx_term;

    // Match status against enables, gating the transmit term once more.
    always_comb begin
        tx_term = sr1[B_SR1_TXRDY] && cr1[B_SR1_TXRDY] && cr1[B_CR1_TXEIE];
        rx_term = sr1[B_SR1_RXRDY] && cr1[B_SR1_RXRDY];
        irq     = tx_term || rx_term;
    end

endmodule

// File: rtl/uart_regs.sv
// Module: register bank of a serial port with a one-character receive buffer.
// Assumes single-cycle bus requests; read data is registered; no FIFOs.
module uart_regs
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              irq
);

    localparam int PAD_W = DATA_W - REG_W;

    wr_sel_t          wr;
    rd_sel_t          rd;
    logic [REG_W-1:0] wlo;
    logic [PAD_W-1:0] unused_wdata_hi;
    logic             soft_rst;
    logic             rx_full;
    logic [REG_W-1:0] rx_hold;
    logic [REG_W-1:0] cr1_q, cr2_q, cr3_q, fcr_q, bmod_q, bcnt_q, msec_q;
    logic [REG_W-1:0] sr1_q, sr2_q;
    logic [REG_W-1:0] sr1_v, sr2_v, test_v, rd_word;

    assign wlo             = bus_wdata[REG_W-1:0];
    assign unused_wdata_hi = bus_wdata[DATA_W-1:REG_W];
    assign soft_rst        = wr.cr2 && !wlo[B_CR2_NRST];
    assign rx_ready        = !rx_full;

    uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr       (wr),
        .rd       (rd)
    );

    uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rx_valid (rx_valid),
        .rx_break (rx_break),
        .rx_byte  (rx_byte),
        .pop      (rd == RS_RXD),
        .full     (rx_full),
        .hold     (rx_hold)
    );

    // Control, baud and modulator storage with the soft-reset path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr1_q  <= '0;
            cr2_q  <= RV_CR2;
            cr3_q  <= RV_CR3;
            bmod_q <= '0;
            bcnt_q <= RV_BCNT;
        end else if (soft_rst) begin
            cr1_q  <= '0;
            cr2_q  <= wlo | RV_CR2;
            cr3_q  <= RV_CR3;
            bmod_q <= '0;
            bcnt_q <= RV_BCNT;
        end else begin
            if (wr.cr1)  cr1_q  <= wlo;
            if (wr.cr2)  cr2_q  <= wlo;
            if (wr.cr3)  cr3_q  <= wlo;
            if (wr.bmod) bmod_q <= wlo;
            if (wr.bcnt) bcnt_q <= wlo;
        end
    end

    // FIFO-control and millisecond storage, untouched by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q  <= '0;
            msec_q <= '0;
        end else begin
            if (wr.fcr)  fcr_q  <= wlo;
            if (wr.msec) msec_q <= wlo;
        end
    end

    // Static status bits with write-one-to-clear on the masked positions.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sr1_q <= RV_SR1;
            sr2_q <= RV_SR2;
        end else begin
            if (wr.sr1) sr1_q <= sr1_q & ~(wlo & W1C_SR1);
            if (wr.sr2) sr2_q <= sr2_q & ~(wlo & W1C_SR2);
        end
    end

    // Compose the status views from stored bits and buffer state.
    always_comb begin
        sr1_v = sr1_q;
        sr2_v = sr2_q;
        test_v = RV_TEST;
        sr1_v[B_SR1_RXRDY] = rx_full;
        sr2_v[B_SR2_DRDY]  = rx_full;
        test_v[B_TST_RXMT] = !rx_full;
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd)
            RS_RXD:  rd_word = rx_hold | (REG_W'(rx_full) << B_RXD_CHRDY);
            RS_CR1:  rd_word = cr1_q;
            RS_CR2:  rd_word = cr2_q;
            RS_CR3:  rd_word = cr3_q;
            RS_FCR:  rd_word = fcr_q;
            RS_SR1:  rd_word = sr1_v;
            RS_SR2:  rd_word = sr2_v;
            RS_BMOD: rd_word = bmod_q;
            RS_BCNT: rd_word = bcnt_q;
            RS_MSEC: rd_word = msec_q;
            RS_TEST: rd_word = test_v;
            default: rd_word = '0;
        endcase
    end

    // Register the read data; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= {{PAD_W{1'b0}}, rd_word};
        end
    end

    // Pass a transmit write on as a one-cycle strobe when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= wr.txd && cr2_q[B_CR2_TXON];
            if (wr.txd && cr2_q[B_CR2_TXON]) tx_byte <= wlo[BYTE_W-1:0];
        end
    end

    uart_irq_gen u_irq (
        .sr1 (sr1_v),
        .cr1 (cr1_q),
        .irq (irq)
    );

endmodule

// File: rtl/uart_regs_chk.sv
// Module: property checker for the register bank, bound to uart_regs.
// Assumes the default 12-bit address; observes ports and control 1.
module uart_regs_chk
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              irq,
    input logic [REG_W-1:0]  cr1
);

    logic [IDX_W-1:0]  idx;
    logic              nrst_wr;
    logic [DATA_W-2:0] unused_chk_wdata;

    assign idx              = IDX_W'(bus_addr[ADDR_W-1:2]);
    assign nrst_wr          = bus_req && bus_we && idx == IX_CR2 && !bus_wdata[0];
    assign unused_chk_wdata = bus_wdata[DATA_W-1:1];

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_req && !bus_we) |-> bus_rdata == '0); // R2
    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_req && bus_we && idx == IX_TXD)); // R6
    AST_SOFT_RST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        nrst_wr |=> rx_ready); // R5
    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !nrst_wr) |=> !rx_ready); // R7
    AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && idx == IX_RXD && !rx_ready) |=> rx_ready); // R8
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr1[B_SR1_RXRDY] && !cr1[B_SR1_TXRDY]) |-> !irq); // R9

endmodule

bind uart_regs uart_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .cr1       (cr1_q)
);

// File: tb/uart_regs_tb.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module uart_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic        rx_break = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    logic [15:0] m_cr1, m_cr2, m_cr3, m_fcr, m_bmod, m_bcnt, m_msec, m_buf;
    bit          m_full;

    always #4 clk = ~clk;

    uart_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_break(rx_break), .rx_byte(rx_byte), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_soft();
        m_cr1 = 16'h0; m_cr2 = 16'h0001; m_cr3 = 16'h0700;
        m_bmod = 16'h0; m_bcnt = 16'h0004; m_buf = 16'h4000; m_full = 1'b0;
    endtask

    task automatic m_write(input logic [9:0] idx, input logic [31:0] d);
        case (idx)
            10'h020: m_cr1 = d[15:0];
            10'h021: begin
                if (!d[0]) m_soft();
                m_cr2 = d[15:0] | 16'h0001;
            end
            10'h022: m_cr3 = d[15:0];
            10'h024: m_fcr = d[15:0];
            10'h029: m_bcnt = d[15:0];
            10'h02A: m_bmod = d[15:0];
            10'h02C: m_msec = d[15:0];
            default: ;
        endcase
    endtask

    task automatic m_read(input logic [9:0] idx, output logic [31:0] e);
        case (idx)
            10'h000: begin
                e = {16'h0, m_buf | (m_full ? 16'h8000 : 16'h0)};
                m_full = 1'b0;
            end
            10'h020: e = {16'h0, m_cr1};
            10'h021: e = {16'h0, m_cr2};
            10'h022: e = {16'h0, m_cr3};
            10'h024: e = {16'h0, m_fcr};
            10'h025: e = 32'h6040 | (m_full ? 32'h0200 : 32'h0);
            10'h026: e = 32'h4028 | (m_full ? 32'h0001 : 32'h0);
            10'h02A: e = {16'h0, m_bmod};
            10'h02B: e = {16'h0, m_bcnt};
            10'h02C: e = {16'h0, m_msec};
            10'h02D: e = 32'h0040 | (m_full ? 32'h0 : 32'h0020);
            default: e = 32'h0;
        endcase
    endtask

    task automatic m_rx(input logic [7:0] b, input bit brk);
        if (!m_full) begin
            m_full = 1'b1;
            m_buf = brk ? 16'h0800 : {8'h0, b};
        end
    endtask

    function automatic bit exp_irq();
        return (m_cr1[13] && m_cr1[6]) || (m_full && m_cr1[9]);
    endfunction

    task automatic check_pins(input string tag);
        check(irq == exp_irq(), {tag, " R9 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
        check(rx_ready == !m_full, {tag, " R7 rx_ready"}, {31'h0, rx_ready},
              {31'h0, !m_full});
    endtask

    task automatic do_write(input logic [9:0] idx, input logic [31:0] d, input string tag);
        bit en;
        en = m_cr2[2];
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        m_write(idx, d);
        if (idx == 10'h010) begin
            check(tx_valid == en, {tag, " R6 tx_valid"}, {31'h0, tx_valid}, {31'h0, en});
            if (en) check(tx_byte == d[7:0], {tag, " R6 tx_byte"}, {24'h0, tx_byte},
                          {24'h0, d[7:0]});
        end else begin
            check(tx_valid == 1'b0, {tag, " R6 no strobe"}, {31'h0, tx_valid}, 32'h0);
        end
        check_pins(tag);
    endtask

    task automatic do_read(input logic [9:0] idx, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = {idx, 2'b00};
        @(negedge clk);
        bus_req = 1'b0;
        m_read(idx, e);
        check(bus_rdata == e, tag, bus_rdata, e);
        @(negedge clk);
        check(bus_rdata == 32'h0, {tag, " R2 idle zero"}, bus_rdata, 32'h0);
        check_pins(tag);
    endtask

    task automatic do_rx(input logic [7:0] b, input bit brk, input string tag);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_break = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
        m_rx(b, brk);
        check_pins(tag);
    endtask

    function automatic logic [9:0] pick_idx(input int unsigned r);
        logic [9:0] tbl [16];
        tbl = '{10'h000, 10'h010, 10'h020, 10'h021, 10'h022, 10'h023, 10'h024,
                10'h025, 10'h026, 10'h029, 10'h02A, 10'h02B, 10'h02C, 10'h02D,
                10'h005, 10'h3FF};
        return tbl[r % 16];
    endfunction

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        void'($urandom(32'd7321));
        m_soft(); m_fcr = 16'h0; m_msec = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R4: reset values.
        check(bus_rdata == 32'h0 && tx_valid == 1'b0, "R4 outputs after reset",
              bus_rdata, 32'h0);
        check_pins("R4");
        foreach (m_cr1[i]) begin end
        for (int k = 0; k < 16; k++) do_read(pick_idx(k), "R4 R1 reset read");

        // R1/R3: storage width, increment alias, read-zero and ignored writes.
        do_write(10'h020, 32'hABCD_1234, "R3 cr1");
        do_read(10'h020, "R3 cr1 low 16 bits");
        do_write(10'h029, 32'h5555_0077, "R3 inc->count");
        do_read(10'h02B, "R3 count via inc");
        do_read(10'h029, "R3 inc reads zero");
        do_write(10'h02B, 32'h0000_0999, "R3 count write ignored");
        do_write(10'h023, 32'h0000_FFFF, "R3 cr4 write");
        do_read(10'h023, "R3 cr4 reads zero");
        do_write(10'h005, 32'h0000_FFFF, "R1 unknown write");
        do_read(10'h005, "R1 unknown reads zero");
        do_read(10'h02B, "R1 count unchanged");
        do_write(10'h024, 32'h1_2345, "R3 fcr");
        do_write(10'h02C, 32'h0000_03E8, "R3 msec");

        // R6: transmit gated by control 2 bit 2.
        do_write(10'h010, 32'h0000_0041, "R6 tx disabled");
        do_write(10'h021, 32'h0000_0007, "R6 enable tx");
        do_write(10'h010, 32'h0000_01C3, "R6 tx enabled");
        do_read(10'h025, "R6 transmit-ready kept");

        // R7/R8/R9: receive path, drop when full, interrupt enables.
        do_write(10'h020, 32'h0000_0200, "R9 rx irq enable");
        do_rx(8'h3C, 1'b0, "R7 first byte");
        do_rx(8'h99, 1'b0, "R7 dropped while full");
        do_read(10'h026, "R7 data-ready");
        do_read(10'h02D, "R7 rx-empty clear");
        do_read(10'h000, "R8 read full");
        do_read(10'h000, "R8 read empty");
        do_rx(8'h00, 1'b1, "R7 break");
        do_read(10'h000, "R7 break pattern");
        do_write(10'h020, 32'h0000_2000, "R9 tx enable without gate");
        do_write(10'h020, 32'h0000_2040, "R9 tx enable with gate");

        // R10: status writes leave live and reset-set bits.
        do_rx(8'h11, 1'b0, "R10 fill");
        do_write(10'h025, 32'hFFFF_FFFF, "R10 sr1 all ones");
        do_write(10'h026, 32'hFFFF_FFFF, "R10 sr2 all ones");
        do_read(10'h025, "R10 sr1 kept");
        do_read(10'h026, "R10 sr2 kept");

        // R5: soft reset keeps FIFO control and millisecond.
        do_write(10'h022, 32'h0000_0123, "R5 cr3 set");
        do_write(10'h021, 32'h0000_4006, "R5 soft reset");
        for (int k = 0; k < 14; k++) do_read(pick_idx(k + 2), "R5 after soft reset");

        // R11: arrival coincident with a soft reset, then with an empty read.
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {10'h021, 2'b00}; bus_wdata = 32'h6;
        rx_valid = 1'b1; rx_byte = 8'hE7;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
        m_write(10'h021, 32'h6);
        check(rx_ready == 1'b1, "R11 reset beats arrival", {31'h0, rx_ready}, 32'h1);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        rx_valid = 1'b1; rx_byte = 8'h5A;
        @(negedge clk);
        bus_req = 1'b0; rx_valid = 1'b0;
        m_read(10'h000, e);
        m_rx(8'h5A, 1'b0);
        check(bus_rdata == e, "R11 read sees old buffer", bus_rdata, e);
        do_read(10'h000, "R11 byte kept");

        // Random traffic across all indices.
        for (int n = 0; n < 600; n++) begin
            int unsigned op;
            logic [9:0]  ix;
            logic [31:0] d;
            op = $urandom % 3;
            ix = pick_idx($urandom);
            d  = $urandom;
            if (ix == 10'h021 && ($urandom % 8) != 0) d[0] = 1'b1;
            case (op)
                0: do_write(ix, d, "R1 R3 R5 R10 random write");
                1: do_read(ix, "R1 R8 random read");
                default: do_rx(d[7:0], d[8] && d[9], "R7 random arrival");
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule